// File: doc/BRIEF.md
# Auto-Reload Eight-Bit Interval Timer

This block is an up-counting interval timer with a separate reload register. Software reaches it through a small register bus with two locations. One location holds the count and its reload value. The other holds a control byte that carries an enable bit and a mode field. A free-running divide-by-four prescaler paces the count. When the count passes its maximum, it wraps to the reload value and raises an interrupt request line. That line stays high until a clear strobe arrives.

Whether the timer is stopped or running changes what a write to the data location does. While stopped, the write seeds the counter as well as the reload register. While running, the write only stages the next reload value. Reading the count takes precedence over counting: an increment that falls due in a read cycle is dropped, not deferred.

Top module: `timer8_autoreload`

## Requirements
- R1: After a synchronous reset the counter, reload register, control byte and interrupt line are all 0, so the timer is not counting.
- R2: The timer runs when control bit 4 is 1 and control bits 7:6 equal binary 10. While it runs, the counter advances by one on every fourth rising edge counted from the end of reset.
- R3: A write to the data location (acc_addr = 0) while the timer is not running loads the written byte into both the reload register and the counter.
- R4: A write to the data location while the timer runs changes only the reload register. The counter keeps its own sequence.
- R5: When the counter advances from FFh, it takes the value the reload register held before that edge.
- R6: The advance from FFh sets the interrupt line on that same edge.
- R7: The interrupt line stays high until irq_clr is sampled high. If an overflow and irq_clr fall on the same edge, the line ends up set.
- R8: With acc_addr = 0, acc_rdata shows the live count in the same cycle. In any cycle where acc_rd is high at the data location, a due advance is lost.
- R9: With acc_addr = 1, acc_rdata shows the mode in bits 7:6 and the enable in bit 4. Bits 5 and 3:0 read as 0.
- R10: With the enable set but a mode other than binary 10, the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 1 | Location select: 0 data, 1 control |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe for the data location; blocks a due count advance |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected location (combinational) |
| irq_clr | input | 1 | Clears the interrupt line |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can fall on the same edge. The first pair is an overflow and an interrupt clear. The bench seeds the counter with FFh while stopped, starts the timer, and holds irq_clr high across the next prescaler tick. The line must then read high in the cycle after the wrap and low only once the clear outlasts it. The second pair is a data read and a prescaler tick. A read held across several ticks must leave the count frozen. Every cycle is judged against a bench model built from the requirements.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    localparam int unsigned BUS_W = 8;
    localparam int unsigned EN_BIT = 4;
    localparam int unsigned MODE_LSB = 6;

    typedef enum logic {
        LOC_DATA = 1'b0,
        LOC_CTRL = 1'b1
    } loc_e;

    typedef enum logic [1:0] {
        MODE_IDLE0  = 2'b00,
        MODE_IDLE1  = 2'b01,
        MODE_TIMER  = 2'b10,
        MODE_IDLE3  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  enable;
    } ctrl_t;

    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_data;
    } bus_op_t;

    function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] d);
        ctrl_t c;
        c.mode   = mode_e'(d[MODE_LSB +: 2]);
        c.enable = d[EN_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] d;
        d = '0;
        d[MODE_LSB +: 2] = c.mode;
        d[EN_BIT] = c.enable;
        return d;
    endfunction

    function automatic logic ctrl_running(input ctrl_t c);
        return c.enable && (c.mode == MODE_TIMER);
    endfunction

endpackage

// File: rtl/timer8_prescale.sv
module timer8_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/timer8_regs.sv
module timer8_regs
    import timer8_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [BUS_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] preload_q,
    output logic             running
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: MODE_IDLE0, enable: 1'b0};
        end else if (op.wr_ctrl) begin
            ctrl_q <= ctrl_unpack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q <= '0;
        end else if (op.wr_data) begin
            preload_q <= wdata[CNT_W-1:0];
        end
    end

    assign running = ctrl_running(ctrl_q);
endmodule

// File: rtl/timer8_count.sv
module timer8_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             seed,
    input  logic [CNT_W-1:0] seed_val,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count_q,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assign wrap = adv && (count_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wrap) begin
            count_q <= preload;
        end else if (adv) begin
            count_q <= count_q + 1'b1;
        end else if (seed) begin
            count_q <= seed_val;
        end
    end
endmodule

// File: rtl/timer8_irq.sv
module timer8_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (set) begin
            irq_q <= 1'b1;
        end else if (clr) begin
            irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/timer8_autoreload.sv
module timer8_autoreload
    import timer8_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DIV   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_addr,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic [BUS_W-1:0] acc_wdata,
    output logic [BUS_W-1:0] acc_rdata,
    input  logic             irq_clr,
    output logic             irq
);
    loc_e             loc;
    bus_op_t          op;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] count_q;
    logic             running;
    logic             tick;
    logic             adv;
    logic             wrap;

    assign loc        = loc_e'(acc_addr);
    assign op.wr_data = acc_wr && (loc == LOC_DATA);
    assign op.wr_ctrl = acc_wr && (loc == LOC_CTRL);
    assign op.rd_data = acc_rd && (loc == LOC_DATA);

    timer8_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    timer8_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (acc_wdata),
        .ctrl_q    (ctrl_q),
        .preload_q (preload_q),
        .running   (running)
    );

    // a read of the count swallows a due tick
    assign adv = running && tick && !op.rd_data;

    timer8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .seed     (op.wr_data && !running),
        .seed_val (acc_wdata[CNT_W-1:0]),
        .preload  (preload_q),
        .count_q  (count_q),
        .wrap     (wrap)
    );

    timer8_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .set   (wrap),
        .clr   (irq_clr),
        .irq_q (irq)
    );

    always_comb begin
        if (loc == LOC_CTRL) begin
            acc_rdata = ctrl_pack(ctrl_q);
        end else begin
            acc_rdata = BUS_W'(count_q);
        end
    end
endmodule

// File: rtl/timer8_checker.sv
module timer8_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] preload,
    input logic             adv,
    input logic             running,
    input logic             irq,
    input logic             irq_clr,
    input logic             acc_addr,
    input logic             acc_wr,
    input logic             acc_rd,
    input logic [7:0]       acc_wdata,
    input logic [7:0]       acc_rdata
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (adv && count != TOP) |=> count == $past(count) + 1'b1);

    a_r3_seed: assert property (@(posedge clk) disable iff (rst)
        (!running && acc_wr && !acc_addr) |=> count == $past(acc_wdata[CNT_W-1:0]));

    a_r4_staged: assert property (@(posedge clk) disable iff (rst)
        (running && acc_wr && !acc_addr && !adv) |=> $stable(count));

    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (adv && count == TOP) |=> count == $past(preload));

    a_r6_irq_set: assert property (@(posedge clk) disable iff (rst)
        (adv && count == TOP) |=> irq);

    a_r7_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r8_read_block: assert property (@(posedge clk) disable iff (rst)
        (running && acc_rd && !acc_addr) |=> $stable(count));

    always_comb begin
        if (rst == 1'b0 && acc_addr == 1'b1) begin
            a_r9_unused_zero: assert ((acc_rdata & 8'h2F) == 8'h00);
        end
    end
endmodule

bind timer8_autoreload timer8_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .count     (count_q),
    .preload   (preload_q),
    .adv       (adv),
    .running   (running),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata)
);

// File: tb/timer8_autoreload_test.sv
module timer8_autoreload_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       daddr = 1'b0;
    logic       dwr = 1'b0;
    logic       drd = 1'b0;
    logic [7:0] dwdata = 8'h00;
    logic       dclr = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    always #5 clk = ~clk;

    timer8_autoreload uut (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (daddr),
        .acc_wr    (dwr),
        .acc_rd    (drd),
        .acc_wdata (dwdata),
        .acc_rdata (rdata),
        .irq_clr   (dclr),
        .irq       (irq)
    );

    // reference model written from the requirements
    logic [1:0] m_pre;
    logic [7:0] m_cnt, m_pl;
    logic [1:0] m_mode;
    logic       m_en, m_irq;

    always @(posedge clk) begin
        logic run, adv, wrap;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_pl = 0; m_mode = 0; m_en = 0; m_irq = 0;
        end else begin
            run  = m_en && (m_mode == 2'b10);
            adv  = run && (m_pre == 2'd3) && !(drd && daddr == 1'b0);
            wrap = adv && (m_cnt == 8'hFF);
            if (wrap) m_cnt = m_pl;
            else if (adv) m_cnt = m_cnt + 8'd1;
            else if (dwr && daddr == 1'b0 && !run) m_cnt = dwdata;
            if (dwr && daddr == 1'b0) m_pl = dwdata;
            if (dwr && daddr == 1'b1) begin
                m_en = dwdata[4];
                m_mode = dwdata[7:6];
            end
            if (wrap) m_irq = 1'b1;
            else if (dclr) m_irq = 1'b0;
            m_pre = m_pre + 2'd1;
        end
    end

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 0;

    function automatic logic [7:0] model_read(input logic a);
        return a ? {m_mode, 1'b0, m_en, 4'b0000} : m_cnt;
    endfunction

    // monitor: continuous irq comparison plus queued read items
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (mon_on) begin
                n_cmp++;
                if (irq !== m_irq) begin
                    n_bad++;
                    $display("FAIL R6/R7 irq actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
                end
            end
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%02h expected=%02h t=%0t", it.tag, rdata, it.exp, $time);
                end
            end
        end
    end

    task automatic push_exp(input logic a, input string tag);
        item_t it;
        it.exp = model_read(a);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        daddr = a; dwr = 1'b1; dwdata = d;
        @(negedge clk);
        dwr = 1'b0;
    endtask

    task automatic bus_read(input logic a, input string tag);
        @(negedge clk);
        daddr = a; drd = (a == 1'b0);
        #1 push_exp(a, tag);
        @(negedge clk);
        drd = 1'b0;
    endtask

    task automatic hold_read(input int n, input string tag);
        @(negedge clk);
        daddr = 1'b0; drd = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1 push_exp(1'b0, tag);
            @(negedge clk);
        end
        drd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_for(input int n);
        @(negedge clk);
        dclr = 1'b1;
        repeat (n) @(negedge clk);
        dclr = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mon_on = 1;
        // R1 reset state
        bus_read(1'b0, "R1 count after reset");
        bus_read(1'b1, "R1 ctrl after reset");
        // R9 unused bits, R10 non-timer mode with enable
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, "R9 ctrl readback");
        idle(12);
        bus_read(1'b0, "R10 no count in mode 11");
        bus_write(1'b1, 8'h50);
        idle(9);
        bus_read(1'b0, "R10 no count in mode 01");
        // R3 seed while stopped
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h37);
        bus_read(1'b0, "R3 seeded count");
        // R2 counting pace
        bus_write(1'b1, 8'h90);
        idle(9);
        bus_read(1'b0, "R2 count after run");
        idle(5);
        bus_read(1'b0, "R2 count later");
        // R4 write while running
        bus_write(1'b0, 8'h10);
        bus_read(1'b0, "R4 count unaffected");
        // R5/R6 overflow
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'hFC);
        bus_write(1'b1, 8'h90);
        idle(20);
        bus_read(1'b0, "R5 count after reload");
        // R7 clear
        clear_for(1);
        idle(2);
        // R8 read blocks ticks
        hold_read(12, "R8 frozen during read");
        bus_read(1'b0, "R8 after hold");
        // R5 reload uses pre-write value when write meets wrap
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'hFE);
        bus_write(1'b1, 8'h90);
        bus_write(1'b0, 8'h40);
        idle(6);
        bus_read(1'b0, "R5 reload value");
        // R7 overflow and clear on the same edge
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'hFF);
        bus_write(1'b1, 8'h90);
        clear_for(10);
        bus_read(1'b0, "R7 count after clear window");
        idle(2);
        mon_on = 0;
        summary();
        $finish;
    end
endmodule